// File: doc/BRIEF.md
# LIN Break Detector with Automatic Baud Measurement

This block watches the already-synchronized receive line of a UART running in LIN mode. A low period of at least 11 bit times that ends with the line going high is taken as a break. A low period that grows past 22 bit times is reported as an overlong break instead. The bit time used for these counts is the divisor currently programmed into the UART, in clock cycles.

After a valid break the block times the following sync byte (0x55). It counts clock cycles from the sync byte's first falling edge to its fifth falling edge. That span covers eight bit times, so dividing the count by eight gives a new per-bit divisor. When automatic baud detection is enabled, the new divisor is presented with a one-cycle load strobe. If the sync counter runs out first, a sync timeout is flagged and no divisor is loaded.

The block also qualifies the byte receiver's "byte complete" strobe before it pushes into the receive FIFO. With dormant filtering off, every byte is pushed. With it on, only the identifier byte that follows a successful break and sync is pushed. The byte receiver itself sits outside this block.

Top module: `lin_autobaud_det`

## Requirements
- R1: With `lin_en` high, a low period of N clock cycles with floor(N / `cur_div`) >= 11 that ends with `rxd` high sets `brk_flag` one cycle after the first high sample. Shorter low periods leave `brk_flag` low.
- R2: A one-cycle `rd_strobe` clears `brk_flag` on the next cycle.
- R3: When a low period completes its 23rd bit time (23 × `cur_div` cycles), `brk_tmo_err` is set on the next cycle. That low period then does not set `brk_flag` when the line returns high.
- R4: After a valid break, with `abd_en` high, `div_load` pulses for exactly one cycle. The pulse comes one cycle after the sync byte's fifth falling edge is sampled. In the same cycle `new_div` equals the cycle count from the first to the fifth falling edge divided by 8, and it holds that value afterwards.
- R5: The sync counter is DIV_W+3 bits wide and starts from zero when the break ends. If it reaches all ones before the fifth falling edge, `sync_tmo_err` is set, no `div_load` pulse occurs and `new_div` keeps its value.
- R6: With `abd_en` low, a complete sync field produces no `div_load` pulse and leaves `new_div` unchanged.
- R7: With `dormant_en` low, `push_ok` follows `byte_valid` in the same cycle, including for the break and sync bytes.
- R8: With `dormant_en` high, the first `byte_valid` after a successful sync measurement is taken as the sync byte and dropped. The second is pushed through `push_ok`. All other strobes, including the break byte, are blocked.
- R9: With `lin_en` low, no low period sets `brk_flag` or `brk_tmo_err`.
- R10: A one-cycle `rd_strobe` also clears `brk_tmo_err` and `sync_tmo_err` on the next cycle.
- R11: After reset, `brk_flag`, `brk_tmo_err`, `sync_tmo_err`, `div_load` and `new_div` are zero, and with `dormant_en` high a `byte_valid` gives no `push_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Synchronized receive line, idle high |
| cur_div | input | DIV_W | Current bit time in clock cycles |
| lin_en | input | 1 | Enables break and sync handling |
| abd_en | input | 1 | Enables automatic divisor update |
| dormant_en | input | 1 | Keeps break and sync bytes out of the FIFO |
| rd_strobe | input | 1 | Data-register read, clears the flags |
| byte_valid | input | 1 | Byte receiver has completed a byte |
| new_div | output | DIV_W | Measured divisor |
| div_load | output | 1 | One-cycle strobe to load `new_div` |
| brk_flag | output | 1 | Valid break received |
| brk_tmo_err | output | 1 | Low period exceeded 22 bit times |
| sync_tmo_err | output | 1 | Sync counter overflowed |
| push_ok | output | 1 | Qualified FIFO push |

## Verification
Each result has a fixed latency. `brk_flag` appears one cycle after the line is first sampled high. `brk_tmo_err` appears one cycle after the 23rd bit time completes. `div_load` and `new_div` appear one cycle after the fifth falling edge is sampled. Flag clears appear one cycle after the read strobe. `push_ok` is combinational on `byte_valid`. The bench changes the line on falling clock edges and holds each level for a counted number of rising edges. This puts every sample on a known cycle, and it checks each result at the falling edge right after the rising edge that produces it. It checks `push_ok` while its strobe is held between edges.

// File: rtl/lin_ab_pkg.sv
package lin_ab_pkg;

    localparam int unsigned LIN_BRK_MIN_BITS = 11;
    localparam int unsigned LIN_BRK_MAX_BITS = 22;
    localparam int unsigned LIN_SYNC_FALLS   = 5;
    localparam int unsigned LIN_SYNC_SHIFT   = 3;

    typedef enum logic [1:0] {
        DET_IDLE,
        DET_LOW,
        DET_OVERLONG,
        DET_SYNC
    } det_state_e;

    typedef enum logic [1:0] {
        GATE_HOLD,
        GATE_SKIP,
        GATE_OPEN
    } gate_state_e;

    typedef struct packed {
        logic brk;
        logic brk_tmo;
        logic sync_tmo;
    } lin_flags_t;

    // Set has priority over a read clear.
    function automatic lin_flags_t flags_update(lin_flags_t cur, lin_flags_t set, logic clr);
        lin_flags_t res;
        res.brk      = set.brk      | (cur.brk      & ~clr);
        res.brk_tmo  = set.brk_tmo  | (cur.brk_tmo  & ~clr);
        res.sync_tmo = set.sync_tmo | (cur.sync_tmo & ~clr);
        return res;
    endfunction

endpackage

// File: rtl/lin_fall_det.sv
module lin_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic fall_o
);
    logic line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b1;
        else     line_q <= line_i;
    end

    assign fall_o = line_q & ~line_i;
endmodule

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
    parameter int unsigned DIV_W = 20,
    parameter int unsigned CNT_W = 5,
    parameter int unsigned SAT   = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] bits,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

    logic [DIV_W-1:0] presc;
    logic [DIV_W:0]   presc_inc;
    logic             at_edge;

    assign presc_inc = {1'b0, presc} + 1'b1;
    // A zero divisor behaves like one cycle per bit.
    assign at_edge   = presc_inc >= {1'b0, div};
    assign wrap_o    = tick & at_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            presc <= '0;
            bits  <= '0;
        end else if (tick) begin
            if (at_edge) begin
                presc <= '0;
                bits  <= (bits == SAT_V) ? bits : bits + 1'b1;
            end else begin
                presc <= presc_inc[DIV_W-1:0];
            end
        end else if (clr) begin
            presc <= '0;
            bits  <= '0;
        end
    end
endmodule

// File: rtl/lin_sync_meter.sv
module lin_sync_meter #(
    parameter int unsigned CNT_W = 23,
    parameter int unsigned FALLS = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arm,
    input  logic           active,
    input  logic           fall,
    output logic           done,
    output logic           ovf,
    output logic [CNT_W:0] span
);
    localparam int unsigned EDGE_W = $clog2(FALLS + 1);
    localparam logic [EDGE_W-1:0] LAST_E = EDGE_W'(FALLS - 1);

    logic [CNT_W-1:0]  cnt;
    logic [EDGE_W-1:0] edges;

    assign ovf  = active & (cnt == {CNT_W{1'b1}});
    assign done = active & fall & (edges == LAST_E) & ~ovf;
    assign span = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            cnt   <= '0;
            edges <= '0;
        end else if (active) begin
            if (fall && edges == '0) begin
                cnt   <= '0;
                edges <= EDGE_W'(1);
            end else if (!ovf && !done) begin
                cnt <= cnt + 1'b1;
                if (fall) edges <= edges + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lin_rx_gate.sv
module lin_rx_gate
    import lin_ab_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dormant_en,
    input  logic sync_ok,
    input  logic byte_valid,
    output logic push_ok
);
    gate_state_e gst;

    always_ff @(posedge clk) begin
        if (rst) begin
            gst <= GATE_HOLD;
        end else if (sync_ok) begin
            gst <= GATE_SKIP;
        end else if (byte_valid) begin
            case (gst)
                GATE_SKIP: gst <= GATE_OPEN;
                GATE_OPEN: gst <= GATE_HOLD;
                default:   gst <= GATE_HOLD;
            endcase
        end
    end

    assign push_ok = byte_valid & (~dormant_en | (gst == GATE_OPEN));
endmodule

// File: rtl/lin_autobaud_det.sv
module lin_autobaud_det
    import lin_ab_pkg::*;
#(
    parameter int unsigned DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic [DIV_W-1:0] cur_div,
    input  logic             lin_en,
    input  logic             abd_en,
    input  logic             dormant_en,
    input  logic             rd_strobe,
    input  logic             byte_valid,
    output logic [DIV_W-1:0] new_div,
    output logic             div_load,
    output logic             brk_flag,
    output logic             brk_tmo_err,
    output logic             sync_tmo_err,
    output logic             push_ok
);
    localparam int unsigned SYNC_W = DIV_W + LIN_SYNC_SHIFT;
    localparam int unsigned BIT_SAT = LIN_BRK_MAX_BITS + 1;
    localparam int unsigned BIT_W = $clog2(BIT_SAT + 1);
    localparam logic [BIT_W-1:0] MIN_B = BIT_W'(LIN_BRK_MIN_BITS);
    localparam logic [BIT_W-1:0] MAX_B = BIT_W'(LIN_BRK_MAX_BITS);

    det_state_e  state, state_nx;
    lin_flags_t  flags, flag_set;

    logic             fall;
    logic             t_tick, t_clr, t_wrap;
    logic [BIT_W-1:0] t_bits;
    logic             brk_set, tmo_set;
    logic             m_active, m_done, m_ovf;
    logic [SYNC_W:0]  m_span;

    lin_fall_det u_fall (
        .clk    (clk),
        .rst    (rst),
        .line_i (rxd),
        .fall_o (fall)
    );

    assign t_tick = lin_en & ~rxd &
                    (((state == DET_IDLE) & fall) | (state == DET_LOW));
    assign t_clr  = (state != DET_LOW);

    lin_bit_timer #(
        .DIV_W (DIV_W),
        .CNT_W (BIT_W),
        .SAT   (BIT_SAT)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (t_clr),
        .tick   (t_tick),
        .div    (cur_div),
        .bits   (t_bits),
        .wrap_o (t_wrap)
    );

    assign brk_set  = (state == DET_LOW) & lin_en & rxd & (t_bits >= MIN_B);
    assign tmo_set  = (state == DET_LOW) & lin_en & ~rxd & t_wrap & (t_bits == MAX_B);
    assign m_active = (state == DET_SYNC) & lin_en;

    lin_sync_meter #(
        .CNT_W (SYNC_W),
        .FALLS (LIN_SYNC_FALLS)
    ) u_meter (
        .clk    (clk),
        .rst    (rst),
        .arm    (brk_set),
        .active (m_active),
        .fall   (fall),
        .done   (m_done),
        .ovf    (m_ovf),
        .span   (m_span)
    );

    lin_rx_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .dormant_en (dormant_en),
        .sync_ok    (m_done),
        .byte_valid (byte_valid),
        .push_ok    (push_ok)
    );

    always_comb begin
        state_nx = state;
        case (state)
            DET_IDLE: begin
                if (lin_en && fall) state_nx = DET_LOW;
            end
            DET_LOW: begin
                if (!lin_en)      state_nx = DET_IDLE;
                else if (rxd)     state_nx = brk_set ? DET_SYNC : DET_IDLE;
                else if (tmo_set) state_nx = DET_OVERLONG;
            end
            DET_OVERLONG: begin
                if (!lin_en || rxd) state_nx = DET_IDLE;
            end
            DET_SYNC: begin
                if (!lin_en || m_ovf || m_done) state_nx = DET_IDLE;
            end
            default: state_nx = DET_IDLE;
        endcase
    end

    always_comb begin
        flag_set.brk      = brk_set;
        flag_set.brk_tmo  = tmo_set;
        flag_set.sync_tmo = m_ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DET_IDLE;
            flags    <= '0;
            new_div  <= '0;
            div_load <= 1'b0;
        end else begin
            state    <= state_nx;
            flags    <= flags_update(flags, flag_set, rd_strobe);
            div_load <= m_done & abd_en;
            if (m_done && abd_en) new_div <= m_span[LIN_SYNC_SHIFT +: DIV_W];
        end
    end

    assign brk_flag     = flags.brk;
    assign brk_tmo_err  = flags.brk_tmo;
    assign sync_tmo_err = flags.sync_tmo;
endmodule

// File: rtl/lin_autobaud_chk.sv
module lin_autobaud_chk (
    input logic clk,
    input logic rst,
    input logic lin_en,
    input logic abd_en,
    input logic rd_strobe,
    input logic byte_valid,
    input logic brk_set,
    input logic div_load,
    input logic brk_flag,
    input logic sync_tmo_err,
    input logic push_ok
);
    // R4: load strobe lasts a single cycle
    a_r4_load_single: assert property (@(posedge clk) disable iff (rst)
        div_load |=> !div_load);

    // R6: a load needs auto-baud enabled in the cycle before
    a_r6_load_needs_abd: assert property (@(posedge clk) disable iff (rst)
        div_load |-> $past(abd_en));

    // R2: a read with no new break leaves the flag clear
    a_r2_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !brk_set) |=> !brk_flag);

    // R9: break flag only rises while LIN handling is enabled
    a_r9_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_flag) |-> $past(lin_en));

    // R5: an overflowed sync never loads a divisor
    a_r5_no_load_on_tmo: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_tmo_err) |-> !div_load);

    // R8: a push is only granted for a completed byte
    a_r8_push_needs_byte: assert property (@(posedge clk) disable iff (rst)
        push_ok |-> byte_valid);
endmodule

bind lin_autobaud_det lin_autobaud_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .lin_en       (lin_en),
    .abd_en       (abd_en),
    .rd_strobe    (rd_strobe),
    .byte_valid   (byte_valid),
    .brk_set      (brk_set),
    .div_load     (div_load),
    .brk_flag     (brk_flag),
    .sync_tmo_err (sync_tmo_err),
    .push_ok      (push_ok)
);

// File: tb/sim_lin_autobaud_det.sv
module sim_lin_autobaud_det;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 6;  // sync counter of 9 bits, overflow after 512 cycles
    localparam int BT = 4;  // bench bit time for break counting

    typedef struct packed {
        logic [7:0] low;
        logic       brk;
        logic       tmo;
    } bvec_t;

    // break length in cycles at 4 cycles per bit, expected break, expected overlong
    localparam bvec_t VECS [7] = '{
        '{8'd40,  1'b0, 1'b0},
        '{8'd43,  1'b0, 1'b0},
        '{8'd44,  1'b1, 1'b0},
        '{8'd52,  1'b1, 1'b0},
        '{8'd91,  1'b1, 1'b0},
        '{8'd92,  1'b0, 1'b1},
        '{8'd120, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rxd = 1'b1;
    logic [DW-1:0] cur_div = DW'(BT);
    logic          lin_en = 1'b1;
    logic          abd_en = 1'b1;
    logic          dormant_en = 1'b0;
    logic          rd_strobe = 1'b0;
    logic          byte_valid = 1'b0;
    logic [DW-1:0] new_div;
    logic          div_load, brk_flag, brk_tmo_err, sync_tmo_err, push_ok;

    int nchk = 0;
    int nfail = 0;
    int loads = 0;
    logic [DW-1:0] exp_div = '0;

    always #2 clk = ~clk;

    lin_autobaud_det #(.DIV_W(DW)) u0 (
        .clk(clk), .rst(rst), .rxd(rxd), .cur_div(cur_div), .lin_en(lin_en),
        .abd_en(abd_en), .dormant_en(dormant_en), .rd_strobe(rd_strobe),
        .byte_valid(byte_valid), .new_div(new_div), .div_load(div_load),
        .brk_flag(brk_flag), .brk_tmo_err(brk_tmo_err),
        .sync_tmo_err(sync_tmo_err), .push_ok(push_ok)
    );

    always @(negedge clk) if (!rst && div_load) loads++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        rxd = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic read_pulse();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic byte_pulse(input string req, input logic exp);
        byte_valid = 1'b1;
        #1;
        check(req, push_ok, exp);
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic settle();
        hold(1'b1, 530);
        read_pulse();
    endtask

    // break of 13 bits, delimiter, sync byte of bit time t, then two more bytes
    task automatic frame(input int t);
        int l0;
        l0 = loads;
        hold(1'b1, 8);
        hold(1'b0, 13 * BT);
        rxd = 1'b1;
        byte_pulse("R7/R8 break byte", !dormant_en);
        check("R1 frame break", brk_flag, 1);
        hold(1'b1, 2 * t);
        hold(1'b0, t);
        for (int k = 0; k < 3; k++) begin
            hold(1'b1, t);
            hold(1'b0, t);
        end
        hold(1'b1, t);
        rxd = 1'b0;
        @(negedge clk);
        if (abd_en) exp_div = DW'(t);
        check(abd_en ? "R4 load strobe" : "R6 no load", div_load, abd_en);
        check(abd_en ? "R4 new divisor" : "R6 divisor kept", new_div, exp_div);
        hold(1'b0, t - 1);
        check("R4 single pulse", loads - l0, abd_en ? 1 : 0);
        hold(1'b1, t);
        byte_pulse("R7/R8 sync byte", !dormant_en);
        hold(1'b1, 4);
        byte_pulse("R7/R8 identifier", 1'b1);
        hold(1'b1, 4);
        byte_pulse("R7/R8 later byte", !dormant_en);
        read_pulse();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        dormant_en = 1'b1;
        byte_valid = 1'b1;
        #1;
        check("R11 push during reset", push_ok, 0);
        byte_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R11 brk_flag", brk_flag, 0);
        check("R11 brk_tmo_err", brk_tmo_err, 0);
        check("R11 sync_tmo_err", sync_tmo_err, 0);
        check("R11 div_load", div_load, 0);
        check("R11 new_div", new_div, 0);
        byte_pulse("R11 dormant blocks after reset", 1'b0);
        dormant_en = 1'b0;

        // R1 / R3 break-length vectors
        for (int i = 0; i < 7; i++) begin
            hold(1'b1, 6);
            hold(1'b0, int'(VECS[i].low));
            check("R3 overlong while low", brk_tmo_err, VECS[i].tmo);
            rxd = 1'b1;
            @(negedge clk);
            check("R1 break flag", brk_flag, VECS[i].brk);
            check("R3 overlong after rise", brk_tmo_err, VECS[i].tmo);
            settle();
        end

        // R2 read clears break flag
        hold(1'b1, 6);
        hold(1'b0, 60);
        hold(1'b1, 1);
        check("R2 flag set before read", brk_flag, 1);
        read_pulse();
        check("R2 flag cleared by read", brk_flag, 0);

        // R5 sync wait overflow, R10 read clears it
        hold(1'b1, 520);
        check("R5 sync timeout in wait", sync_tmo_err, 1);
        read_pulse();
        check("R10 sync timeout cleared", sync_tmo_err, 0);

        // R3 / R10 overlong flag cleared by read
        hold(1'b0, 100);
        hold(1'b1, 2);
        check("R3 overlong set", brk_tmo_err, 1);
        read_pulse();
        check("R10 overlong cleared", brk_tmo_err, 0);

        // R4 / R7 auto-baud frames, dormant off
        abd_en = 1'b1; dormant_en = 1'b0;
        frame(5);
        frame(7);
        // R8 dormant on
        dormant_en = 1'b1;
        frame(3);
        // R6 auto-baud off, dormant on
        abd_en = 1'b0;
        frame(6);
        abd_en = 1'b1;
        dormant_en = 1'b0;

        // R5 overflow during measurement
        begin
            int l0;
            l0 = loads;
            hold(1'b1, 8);
            hold(1'b0, 52);
            hold(1'b1, 8);
            hold(1'b0, 8);
            hold(1'b1, 600);
            check("R5 sync timeout in measurement", sync_tmo_err, 1);
            check("R5 no load on timeout", loads - l0, 0);
            check("R5 divisor kept", new_div, exp_div);
            read_pulse();
        end

        // R9 disabled: long low ignored
        lin_en = 1'b0;
        hold(1'b1, 4);
        hold(1'b0, 60);
        hold(1'b1, 2);
        check("R9 no break when disabled", brk_flag, 0);
        hold(1'b0, 110);
        hold(1'b1, 2);
        check("R9 no overlong when disabled", brk_tmo_err, 0);
        lin_en = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule